// File: doc/BRIEF.md
# Asynchronous Serial Port with Modem Lines

This block is a byte-wide asynchronous serial transmitter and receiver. It sits on a simple synchronous microprocessor bus. A host selects one of four registers with a two-bit address and a chip select, and uses single-cycle read and write strobes. Writing the data address queues a character for transmission. Reading the data address returns the last received character. Two control registers set parity, receive gating, break output, interrupt masks and the two modem outputs. A status register reports the receive and transmit conditions.

Bit timing comes from an external enable, `tick16`, that pulses once per sixteenth of a bit. The transmitter and receiver use separate parity settings. One maskable interrupt line combines the receive, transmit, error and modem-change conditions. A dedicated pin mirrors the transmit holding register's empty state.

Top module: `sciUart`

## Requirements
- R1: After reset the status register (address 3) reads 0x40, `sdo` is 1, `irq` is 0, `txEmpty` is 1, and both `rtsN` and `dtrN` are 1.
- R2: A character written to address 0 is sent as follows, each bit lasting 16 `tick16` periods: one 0 start bit, then data bits 0 through 7 with bit 0 first, then the optional parity bit, then one 1 stop bit.
- R3: Line control (address 1) sets transmit parity with bit 0 (enable) and bit 1 (odd), and receive parity with bit 2 (enable) and bit 3 (odd). With even parity the ones in data plus parity are even. With odd parity they are odd. The two sides are set independently.
- R4: A falling edge on the gated input starts the receiver. The start bit is checked 8 ticks later, and if the line is high there the receiver returns to idle without receiving. Each further bit is sampled 16 ticks after the one before. A complete character goes to the receive buffer and sets data ready.
- R5: While line control bit 4 (receive enable) is 0, frames on `sdi` are not received and data ready stays 0.
- R6: `txEmpty` always equals status bit 6. It is 0 while a written character waits in the holding register behind one being shifted out.
- R7: Status layout: bit 0 parity error, bit 1 framing error, bit 2 overrun, bit 3 break, bit 4 modem change, bit 5 transmit complete, bit 6 transmit empty, bit 7 data ready. Reading status clears bits 0 to 4. Reading address 0 clears bit 7.
- R8: A received parity bit that does not match the receive parity setting sets the parity error flag. A stop bit sampled as 0 sets the framing error flag.
- R9: Line control bit 5 forces `sdo` to 0 while set. A received frame that is all zero from the start bit through the stop bit sets the break flag.
- R10: A character completing while data ready is still set sets overrun and replaces the buffered character.
- R11: `irq` is the OR of four terms, each gated by a mask bit in address 2: data ready (bit 0), transmit empty (bit 1), any of the four error or break flags (bit 2), and modem change (bit 3).
- R12: A change on `ctsN` or `dsrN` sets the modem change flag only while mask bit 3 is set.
- R13: Transmit complete sets when a stop bit ends with nothing waiting in the holding register. Writing address 0 clears it.
- R14: Address 2 bit 4 drives `rtsN` low and bit 5 drives `dtrN` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Enable pulse at sixteen times the bit rate |
| csel | input | 1 | Register select |
| rdStb | input | 1 | Read strobe |
| wrStb | input | 1 | Write strobe |
| addr | input | 2 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid while selected |
| sdi | input | 1 | Serial input |
| sdo | output | 1 | Serial output, idle high |
| irq | output | 1 | Masked interrupt request |
| txEmpty | output | 1 | Transmit holding register empty |
| ctsN | input | 1 | Clear-to-send, active low |
| dsrN | input | 1 | Data-set-ready, active low |
| rtsN | output | 1 | Request-to-send, active low |
| dtrN | output | 1 | Data-terminal-ready, active low |

## Verification
The hardest state to reach from the ports is the receiver deciding a frame mid-stream. That covers a short low glitch rejected at the start-bit check, a second frame landing on an unread one, and a frame held low through its stop bit. The bench has its own serial driver that builds each frame bit by bit, with a chosen stop value and an optionally inverted parity bit. It holds `sdi` for whole multiples of the bit time, so each of these cases is produced on purpose and not by chance. A holding register occupied behind a busy shifter is reached by writing two characters back to back.

// File: rtl/sciPkg.sv
package sciPkg;
  localparam int DATA_W = 8;
  localparam int OVERSAMPLE = 16;
  localparam int CTL_W = 6;

  localparam logic [1:0] ADDR_DATA  = 2'd0;
  localparam logic [1:0] ADDR_LINE  = 2'd1;
  localparam logic [1:0] ADDR_MODEM = 2'd2;
  localparam logic [1:0] ADDR_STAT  = 2'd3;

  // line control fields
  localparam int LC_TXPE = 0;
  localparam int LC_TXODD = 1;
  localparam int LC_RXPE = 2;
  localparam int LC_RXODD = 3;
  localparam int LC_RXEN = 4;
  localparam int LC_BRK = 5;

  // modem / mask fields
  localparam int MC_RDYIE = 0;
  localparam int MC_TXEIE = 1;
  localparam int MC_ERRIE = 2;
  localparam int MC_MSIE = 3;
  localparam int MC_RTS = 4;
  localparam int MC_DTR = 5;

  typedef enum logic [2:0] {
    BIT_IDLE, BIT_START, BIT_DATA, BIT_PAR, BIT_STOP
  } bitKind_e;

  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic txEnd;
    logic rxSample;
    logic rxDone;
  } strobes_t;
endpackage

// File: rtl/sciSeq.sv
module sciSeq
  import sciPkg::*;
#(
  parameter int DATA_BITS = DATA_W,
  parameter int OVS = OVERSAMPLE
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     txFull,
  input  logic     txParEn,
  input  logic     rxParEn,
  input  logic     lineIn,
  input  logic     lineFall,
  output strobes_t stb,
  output bitKind_e txKind,
  output bitKind_e rxKind
);
  localparam int TICK_W = $clog2(OVS);
  localparam int CNT_W = $clog2(DATA_BITS);
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(OVS - 1);
  localparam logic [TICK_W-1:0] MID_TICK = TICK_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_BITS - 1);

  bitKind_e txState, rxState;
  logic [TICK_W-1:0] txTicks, rxTicks;
  logic [CNT_W-1:0] txIdx, rxIdx;
  logic txBitEnd, rxBitEnd;

  assign txBitEnd = tick && (txTicks == LAST_TICK) && (txState != BIT_IDLE);
  assign rxBitEnd = tick && (rxTicks == LAST_TICK)
                    && (rxState inside {BIT_DATA, BIT_PAR, BIT_STOP});

  always_ff @(posedge clk) begin
    if (rst) begin
      txState <= BIT_IDLE;
      txTicks <= '0;
      txIdx <= '0;
    end else if (txState == BIT_IDLE) begin
      if (txFull) begin
        txState <= BIT_START;
        txTicks <= '0;
      end
    end else if (tick) begin
      if (txTicks == LAST_TICK) begin
        txTicks <= '0;
        case (txState)
          BIT_START: begin
            txState <= BIT_DATA;
            txIdx <= '0;
          end
          BIT_DATA: begin
            if (txIdx == LAST_BIT) txState <= txParEn ? BIT_PAR : BIT_STOP;
            else txIdx <= txIdx + 1'b1;
          end
          BIT_PAR: txState <= BIT_STOP;
          default: txState <= BIT_IDLE;
        endcase
      end else begin
        txTicks <= txTicks + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxState <= BIT_IDLE;
      rxTicks <= '0;
      rxIdx <= '0;
    end else begin
      case (rxState)
        BIT_IDLE: begin
          if (lineFall) begin
            rxState <= BIT_START;
            rxTicks <= '0;
          end
        end
        BIT_START: begin
          if (tick) begin
            if (rxTicks == MID_TICK) begin
              rxTicks <= '0;
              rxIdx <= '0;
              rxState <= lineIn ? BIT_IDLE : BIT_DATA;
            end else begin
              rxTicks <= rxTicks + 1'b1;
            end
          end
        end
        default: begin
          if (tick) begin
            if (rxTicks == LAST_TICK) begin
              rxTicks <= '0;
              case (rxState)
                BIT_DATA: begin
                  if (rxIdx == LAST_BIT) rxState <= rxParEn ? BIT_PAR : BIT_STOP;
                  else rxIdx <= rxIdx + 1'b1;
                end
                BIT_PAR: rxState <= BIT_STOP;
                default: rxState <= BIT_IDLE;
              endcase
            end else begin
              rxTicks <= rxTicks + 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    stb.txLoad = (txState == BIT_IDLE) && txFull;
    stb.txShift = txBitEnd && (txState == BIT_DATA);
    stb.txEnd = txBitEnd && (txState == BIT_STOP);
    stb.rxSample = rxBitEnd;
    stb.rxDone = rxBitEnd && (rxState == BIT_STOP);
  end

  assign txKind = txState;
  assign rxKind = rxState;

  // R2
  tx_hold_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (txState != BIT_IDLE && !tick) |=> $stable(txState));

  // R2
  tx_stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    stb.txEnd |=> (txState == BIT_IDLE));

  // R4
  false_start_chk: assert property (@(posedge clk) disable iff (rst)
    (rxState == BIT_START && tick && rxTicks == MID_TICK && lineIn)
      |=> (rxState == BIT_IDLE));
endmodule

// File: rtl/sciRegs.sv
module sciRegs
  import sciPkg::*;
#(
  parameter int DATA_BITS = DATA_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 csel,
  input  logic                 rdStb,
  input  logic                 wrStb,
  input  logic [1:0]           addr,
  input  logic [DATA_BITS-1:0] wrData,
  output logic [DATA_BITS-1:0] rdData,
  input  logic                 sdi,
  output logic                 sdo,
  output logic                 irq,
  output logic                 txEmpty,
  input  logic                 ctsN,
  input  logic                 dsrN,
  output logic                 rtsN,
  output logic                 dtrN,
  input  strobes_t             stb,
  input  bitKind_e             txKind,
  input  bitKind_e             rxKind,
  output logic                 txFull,
  output logic                 txParEn,
  output logic                 rxParEn,
  output logic                 lineIn,
  output logic                 lineFall
);
  localparam int PAD_W = DATA_BITS - CTL_W;

  logic [DATA_BITS-1:0] txHold, txSh, rxSh, rxBuf;
  logic [CTL_W-1:0] lineCtl, modemCtl;
  logic txPar, rxParBit;
  logic peFlag, feFlag, oeFlag, brkFlag, msFlag, tcFlag, drFlag;
  logic sdiMeta, sdiSync, lineP;
  logic ctsS1, ctsS2, ctsS3, dsrS1, dsrS2, dsrS3;
  logic modemChange, wrHit, rdHit, rdBuf, rdStat, wrBuf;
  logic rxParErr, allZero, lineBit;
  logic [DATA_BITS-1:0] status;

  assign wrHit = csel && wrStb;
  assign rdHit = csel && rdStb;
  assign wrBuf = wrHit && (addr == ADDR_DATA);
  assign rdBuf = rdHit && (addr == ADDR_DATA);
  assign rdStat = rdHit && (addr == ADDR_STAT);

  assign txParEn = lineCtl[LC_TXPE];
  assign rxParEn = lineCtl[LC_RXPE];
  assign lineIn = lineCtl[LC_RXEN] ? sdiSync : 1'b1;
  assign lineFall = lineP && !lineIn;
  assign modemChange = (ctsS2 ^ ctsS3) || (dsrS2 ^ dsrS3);

  assign rxParErr = lineCtl[LC_RXPE]
                    && (rxParBit != ((^rxSh) ^ lineCtl[LC_RXODD]));
  assign allZero = (rxSh == '0) && !lineIn
                   && (!lineCtl[LC_RXPE] || !rxParBit);

  always_ff @(posedge clk) begin
    if (rst) begin
      sdiMeta <= 1'b1;
      sdiSync <= 1'b1;
      lineP <= 1'b1;
      {ctsS1, ctsS2, ctsS3} <= 3'b111;
      {dsrS1, dsrS2, dsrS3} <= 3'b111;
    end else begin
      sdiMeta <= sdi;
      sdiSync <= sdiMeta;
      lineP <= lineIn;
      {ctsS1, ctsS2, ctsS3} <= {ctsN, ctsS1, ctsS2};
      {dsrS1, dsrS2, dsrS3} <= {dsrN, dsrS1, dsrS2};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txHold <= '0;
      txSh <= '0;
      txPar <= 1'b0;
      txFull <= 1'b0;
      rxSh <= '0;
      rxBuf <= '0;
      rxParBit <= 1'b0;
      lineCtl <= '0;
      modemCtl <= '0;
      {peFlag, feFlag, oeFlag, brkFlag, msFlag, tcFlag, drFlag} <= '0;
    end else begin
      if (stb.txLoad) begin
        txSh <= txHold;
        txPar <= (^txHold) ^ lineCtl[LC_TXODD];
        txFull <= 1'b0;
      end else if (stb.txShift) begin
        txSh <= txSh >> 1;
      end

      if (wrBuf) begin
        txHold <= wrData;
        txFull <= 1'b1;
        tcFlag <= 1'b0;
      end else if (stb.txEnd && !txFull) begin
        tcFlag <= 1'b1;
      end

      if (wrHit && addr == ADDR_LINE) lineCtl <= wrData[CTL_W-1:0];
      if (wrHit && addr == ADDR_MODEM) modemCtl <= wrData[CTL_W-1:0];

      if (rdBuf) drFlag <= 1'b0;
      if (rdStat) {peFlag, feFlag, oeFlag, brkFlag, msFlag} <= '0;

      if (stb.rxSample && rxKind == BIT_DATA) rxSh <= {lineIn, rxSh[DATA_BITS-1:1]};
      if (stb.rxSample && rxKind == BIT_PAR) rxParBit <= lineIn;

      if (stb.rxDone) begin
        rxBuf <= rxSh;
        drFlag <= 1'b1;
        if (drFlag && !rdBuf) oeFlag <= 1'b1;
        if (rxParErr) peFlag <= 1'b1;
        if (!lineIn) feFlag <= 1'b1;
        if (allZero) brkFlag <= 1'b1;
      end

      if (modemChange && modemCtl[MC_MSIE]) msFlag <= 1'b1;
    end
  end

  assign status = {drFlag, !txFull, tcFlag, msFlag, brkFlag, oeFlag, feFlag, peFlag};
  assign txEmpty = !txFull;

  always_comb begin
    case (addr)
      ADDR_DATA:  rdData = rxBuf;
      ADDR_LINE:  rdData = {{PAD_W{1'b0}}, lineCtl};
      ADDR_MODEM: rdData = {{PAD_W{1'b0}}, modemCtl};
      default:    rdData = status;
    endcase
  end

  assign irq = (drFlag && modemCtl[MC_RDYIE])
             || (!txFull && modemCtl[MC_TXEIE])
             || ((peFlag || feFlag || oeFlag || brkFlag) && modemCtl[MC_ERRIE])
             || (msFlag && modemCtl[MC_MSIE]);

  always_comb begin
    case (txKind)
      BIT_START: lineBit = 1'b0;
      BIT_DATA:  lineBit = txSh[0];
      BIT_PAR:   lineBit = txPar;
      default:   lineBit = 1'b1;
    endcase
  end
  assign sdo = lineBit && !lineCtl[LC_BRK];

  assign rtsN = !modemCtl[MC_RTS];
  assign dtrN = !modemCtl[MC_DTR];

  // R6
  txe_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(txEmpty) |-> $past(stb.txLoad));

  // R10
  overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.rxDone && drFlag && !rdBuf) |=> oeFlag);

  // R7
  stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rdStat && !stb.rxDone) |=> !(peFlag || feFlag || oeFlag || brkFlag));

  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (modemCtl[3:0] == 4'b0000) |-> !irq);

  // R13
  tc_set_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.txEnd && !txFull && !wrBuf) |=> tcFlag);

  // R12
  ms_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!modemCtl[MC_MSIE] && !msFlag) |=> !msFlag);
endmodule

// File: rtl/sciUart.sv
module sciUart
  import sciPkg::*;
#(
  parameter int DATA_BITS = DATA_W,
  parameter int OVS = OVERSAMPLE
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick16,
  input  logic                 csel,
  input  logic                 rdStb,
  input  logic                 wrStb,
  input  logic [1:0]           addr,
  input  logic [DATA_BITS-1:0] wrData,
  output logic [DATA_BITS-1:0] rdData,
  input  logic                 sdi,
  output logic                 sdo,
  output logic                 irq,
  output logic                 txEmpty,
  input  logic                 ctsN,
  input  logic                 dsrN,
  output logic                 rtsN,
  output logic                 dtrN
);
  strobes_t stb;
  bitKind_e txKind, rxKind;
  logic txFull, txParEn, rxParEn, lineIn, lineFall;

  sciSeq #(.DATA_BITS(DATA_BITS), .OVS(OVS)) seq (
    .clk(clk), .rst(rst), .tick(tick16),
    .txFull(txFull), .txParEn(txParEn), .rxParEn(rxParEn),
    .lineIn(lineIn), .lineFall(lineFall),
    .stb(stb), .txKind(txKind), .rxKind(rxKind)
  );

  sciRegs #(.DATA_BITS(DATA_BITS)) regs (
    .clk(clk), .rst(rst), .csel(csel), .rdStb(rdStb), .wrStb(wrStb),
    .addr(addr), .wrData(wrData), .rdData(rdData),
    .sdi(sdi), .sdo(sdo), .irq(irq), .txEmpty(txEmpty),
    .ctsN(ctsN), .dsrN(dsrN), .rtsN(rtsN), .dtrN(dtrN),
    .stb(stb), .txKind(txKind), .rxKind(rxKind),
    .txFull(txFull), .txParEn(txParEn), .rxParEn(rxParEn),
    .lineIn(lineIn), .lineFall(lineFall)
  );
endmodule

// File: tb/sciUart_test.sv
module sciUart_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csel = 1'b0, rdStb = 1'b0, wrStb = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic sdi = 1'b1, ctsN = 1'b1, dsrN = 1'b1;
  logic sdo, irq, txEmpty, rtsN, dtrN;
  logic [1:0] tickCnt = 2'd0;
  logic tick16;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  // each entry: [11] rx odd, [10] rx parity on, [9] tx odd, [8] tx parity on, [7:0] data
  localparam logic [11:0] VECS [6] = '{
    12'h0A5, 12'h13C, 12'h301, 12'h4FE, 12'hC80, 12'h76B
  };

  always #4 clk = ~clk;

  always @(negedge clk) tickCnt <= tickCnt + 2'd1;
  assign tick16 = (tickCnt == 2'd3);

  sciUart uut (
    .clk(clk), .rst(rst), .tick16(tick16), .csel(csel), .rdStb(rdStb),
    .wrStb(wrStb), .addr(addr), .wrData(wrData), .rdData(rdData),
    .sdi(sdi), .sdo(sdo), .irq(irq), .txEmpty(txEmpty),
    .ctsN(ctsN), .dsrN(dsrN), .rtsN(rtsN), .dtrN(dtrN)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    csel = 1'b1; wrStb = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    csel = 1'b0; wrStb = 1'b0;
  endtask

  task automatic busRd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    csel = 1'b1; rdStb = 1'b1; addr = a;
    #1 d = rdData;
    @(negedge clk);
    csel = 1'b0; rdStb = 1'b0;
  endtask

  function automatic logic [11:0] mkFrame(input logic [7:0] d, input logic pe,
      input logic odd, input logic stopBit, input logic flipPar, output int n);
    logic [11:0] f;
    f = 12'h000;
    f[8:1] = d;
    if (pe) begin
      f[9] = (^d) ^ odd ^ flipPar;
      f[10] = stopBit;
      n = 11;
    end else begin
      f[9] = stopBit;
      n = 10;
    end
    return f;
  endfunction

  task automatic sendRx(input logic [11:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      sdi = bits[i];
      repeat (64) @(negedge clk);
    end
  endtask

  task automatic grabTx(input int n, output logic [11:0] got);
    int guard;
    guard = 0;
    got = 12'h000;
    while (sdo !== 1'b0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (32) @(negedge clk);
    got[0] = sdo;
    for (int i = 1; i < n; i++) begin
      repeat (64) @(negedge clk);
      got[i] = sdo;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [11:0] fr, got;
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    busRd(2'd3, r);
    chk("R1 status", r, 8'h40);
    chk("R1 sdo", sdo, 1'b1);
    chk("R1 irq", irq, 1'b0);
    chk("R6 txEmpty reset", txEmpty, 1'b1);
    chk("R1 modem pins", {rtsN, dtrN}, 2'b11);

    // R14 modem outputs
    busWr(2'd2, 8'h30);
    chk("R14 both asserted", {rtsN, dtrN}, 2'b00);
    busWr(2'd2, 8'h10);
    chk("R14 rts only", {rtsN, dtrN}, 2'b01);
    busWr(2'd2, 8'h00);

    // R2 R3 R4 table walk: transmit then receive each vector
    foreach (VECS[v]) begin
      busWr(2'd1, 8'h10 | {4'h0, VECS[v][11:8]});
      fr = mkFrame(VECS[v][7:0], VECS[v][8], VECS[v][9], 1'b1, 1'b0, n);
      busWr(2'd0, VECS[v][7:0]);
      grabTx(n, got);
      chk("R2 R3 tx frame", got, fr);
      repeat (64) @(negedge clk);
      fr = mkFrame(VECS[v][7:0], VECS[v][10], VECS[v][11], 1'b1, 1'b0, n);
      sendRx(fr, n);
      busRd(2'd3, r);
      chk("R4 R7 status after rx", r, 8'hE0);
      busRd(2'd0, r);
      chk("R4 rx data", r, {24'h0, VECS[v][7:0]});
    end

    // R6 R13 holding register occupied behind shifter
    busWr(2'd1, 8'h10);
    busWr(2'd0, 8'h5A);
    busWr(2'd0, 8'hC3);
    chk("R6 txEmpty busy", txEmpty, 1'b0);
    busRd(2'd3, r);
    chk("R6 R13 status busy", r & 8'h60, 8'h00);
    repeat (1500) @(negedge clk);
    busRd(2'd3, r);
    chk("R13 R6 status done", r & 8'h60, 8'h60);
    chk("R6 txEmpty done", txEmpty, 1'b1);

    // R5 receiver disabled
    busWr(2'd1, 8'h00);
    fr = mkFrame(8'h33, 1'b0, 1'b0, 1'b1, 1'b0, n);
    sendRx(fr, n);
    busRd(2'd3, r);
    chk("R5 gated off", r & 8'h8F, 8'h00);

    // R4 short glitch rejected
    busWr(2'd1, 8'h10);
    sdi = 1'b0;
    repeat (12) @(negedge clk);
    sdi = 1'b1;
    repeat (200) @(negedge clk);
    busRd(2'd3, r);
    chk("R4 glitch", r & 8'h8F, 8'h00);

    // R8 parity error, R11 error interrupt, R7 read clear
    busWr(2'd1, 8'h14);
    fr = mkFrame(8'h01, 1'b1, 1'b0, 1'b1, 1'b1, n);
    sendRx(fr, n);
    busWr(2'd2, 8'h04);
    chk("R11 error irq", irq, 1'b1);
    busRd(2'd3, r);
    chk("R8 parity error", r & 8'h8F, 8'h81);
    busRd(2'd3, r);
    chk("R7 errors cleared", r & 8'h1F, 8'h00);
    chk("R11 irq after clear", irq, 1'b0);
    busRd(2'd0, r);
    chk("R8 parity data", r, 8'h01);
    busRd(2'd3, r);
    chk("R7 dr cleared by data read", r & 8'h80, 8'h00);
    busWr(2'd2, 8'h00);

    // R8 framing error
    busWr(2'd1, 8'h10);
    fr = mkFrame(8'h55, 1'b0, 1'b0, 1'b0, 1'b0, n);
    sendRx(fr, n);
    sdi = 1'b1;
    repeat (20) @(negedge clk);
    busRd(2'd3, r);
    chk("R8 framing error", r & 8'h8F, 8'h82);
    busRd(2'd0, r);

    // R9 break detect
    sdi = 1'b0;
    repeat (11 * 64) @(negedge clk);
    sdi = 1'b1;
    repeat (20) @(negedge clk);
    busRd(2'd3, r);
    chk("R9 break flag", r & 8'h8F, 8'h8A);
    busRd(2'd0, r);
    chk("R9 break data", r, 8'h00);

    // R10 overrun
    fr = mkFrame(8'h11, 1'b0, 1'b0, 1'b1, 1'b0, n);
    sendRx(fr, n);
    fr = mkFrame(8'h22, 1'b0, 1'b0, 1'b1, 1'b0, n);
    sendRx(fr, n);
    busRd(2'd3, r);
    chk("R10 overrun flag", r & 8'h8F, 8'h84);
    busRd(2'd0, r);
    chk("R10 newer kept", r, 8'h22);

    // R11 data-ready and transmit-empty interrupts
    fr = mkFrame(8'h7E, 1'b0, 1'b0, 1'b1, 1'b0, n);
    sendRx(fr, n);
    busWr(2'd2, 8'h01);
    chk("R11 ready irq", irq, 1'b1);
    busRd(2'd0, r);
    chk("R11 ready irq cleared", irq, 1'b0);
    busWr(2'd2, 8'h02);
    chk("R11 empty irq", irq, 1'b1);
    busWr(2'd2, 8'h00);

    // R9 break generation
    busWr(2'd1, 8'h30);
    chk("R9 break out", sdo, 1'b0);
    busWr(2'd1, 8'h10);
    chk("R9 break released", sdo, 1'b1);

    // R12 modem change gating
    ctsN = 1'b0;
    repeat (10) @(negedge clk);
    busRd(2'd3, r);
    chk("R12 masked change", r & 8'h10, 8'h00);
    busWr(2'd2, 8'h08);
    chk("R12 no irq yet", irq, 1'b0);
    dsrN = 1'b0;
    repeat (10) @(negedge clk);
    chk("R11 R12 modem irq", irq, 1'b1);
    busRd(2'd3, r);
    chk("R12 modem flag", r & 8'h10, 8'h10);
    chk("R7 modem flag cleared", irq, 1'b0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule